// File: doc/BRIEF.md
# Sectioned Square-Root Carry-Select Adder

This block is a purely combinational 128-bit binary adder. It takes two operands and a carry-in, and returns a 128-bit sum with a carry-out. The carry path is kept short by carry selection. The adder is a string of identical 16-bit sections, and the carry ripples from one section to the next. Inside a section, the bits are split into groups whose widths grow toward the most significant end. The lowest group is a single ripple adder that takes the real incoming carry. Each higher group computes its result twice, once assuming a carry of 0 and once assuming a carry of 1. The carry selected at the group below then picks one of the two results.

The block has no clock and no state. It suits a datapath where the caller registers the operands and the result. The inputs are plain control-free data pins, so no valid/ready handshake applies: the outputs follow the inputs after the combinational delay.

Top module: `sqrt_csel_add`

## Requirements
- R1: For every input, {cout, sum} equals the 129-bit value a + b + cin.
- R2: With a and b both all-ones and cin = 1, sum is all-ones and cout is 1. With a all-ones, b = 0 and cin = 1, sum is zero and cout is 1.
- R3: The lowest group (bits 1..0 of each section) adds with the real incoming carry. With a = b = 0 and cin = 1, sum = 1 and cout = 0.
- R4: In each duplicated group, the carry-1 candidate, read as the value {carry-out, sum}, is exactly one more than the carry-0 candidate. Select 0 passes the carry-0 candidate and select 1 passes the carry-1 candidate.
- R5: Within a 16-bit section the group widths, from least significant, are 2, 2, 3, 4 and 5. A carry is created below each group boundary (bit offsets 2, 4, 7 and 11 of a section) by a = 2^k - 1, b = 1. That carry must give sum = 2^k and cout = 0.
- R6: Each section's carry-out drives the next section's carry-in. A carry created below a 16-bit boundary reaches the section above it.
- R7: Alternating patterns, where a = 0x55..55 and b = 0xAA..AA, make every bit a propagate bit. With cin = 1, the carry then crosses every group and section boundary and gives sum = 0 and cout = 1.
- R8: The outputs depend only on the present inputs, with no storage. A change on the inputs partway through a clock period appears at the outputs in that same period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 128 | First operand |
| b | input | 128 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 128 | Low 128 bits of a + b + cin |
| cout | output | 1 | Bit 128 of a + b + cin |

## Verification
The test drives random operand pairs with both carry-in values. These give broad coverage of the carry selection, but they seldom create long carry chains. The test then adds directed patterns:
- all-zeros, which separates a dead carry-in from a working one;
- all-ones, which ripples the carry through every mux;
- alternating bits, where every bit propagates;
- a low mask plus one at each group offset and each section offset.

A mux that picks the wrong candidate, or a group boundary that is off by one, shows up as a wrong bit at that offset.

// File: rtl/sqrt_csel_pkg.sv
package sqrt_csel_pkg;

  // Width of group idx in a section whose lowest group is g0 bits wide.
  function automatic int grp_width(input int g0, input int idx);
    return (idx == 0) ? g0 : g0 + idx - 1;
  endfunction

  // Bit offset of group idx inside its section.
  function automatic int grp_offset(input int g0, input int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) acc += grp_width(g0, k);
    return acc;
  endfunction

  // Total section width for ngrp groups.
  function automatic int sec_width(input int g0, input int ngrp);
    return grp_offset(g0, ngrp);
  endfunction

endpackage

// File: rtl/csel_fa.sv
module csel_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic hp;
  assign hp = x ^ y;
  assign s  = hp ^ ci;
  assign co = (x & y) | (ci & hp);
endmodule

// File: rtl/csel_rca.sv
module csel_rca #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] chain;
  assign chain[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    csel_fa u_fa (
      .x (x[i]),
      .y (y[i]),
      .ci(chain[i]),
      .s (s[i]),
      .co(chain[i+1])
    );
  end

  assign co = chain[W];
endmodule

// File: rtl/csel_group.sv
module csel_group #(
  parameter int W = 3
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sel,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W-1:0] s_lo, s_hi;
  logic         c_lo, c_hi;

  csel_rca #(.W(W)) u_rca_c0 (
    .x(x), .y(y), .ci(1'b0), .s(s_lo), .co(c_lo)
  );
  csel_rca #(.W(W)) u_rca_c1 (
    .x(x), .y(y), .ci(1'b1), .s(s_hi), .co(c_hi)
  );

  assign s  = sel ? s_hi : s_lo;
  assign co = sel ? c_hi : c_lo;

  // R4: two independent chains must differ by exactly one
  always_comb begin
    if (!$isunknown({x, y}))
      p_cand_step_r4: assert ({c_hi, s_hi} == {c_lo, s_lo} + (W+1)'(1))
        else $error("carry-1 candidate is not carry-0 candidate plus one");
  end
endmodule

// File: rtl/csel_section.sv
module csel_section
  import sqrt_csel_pkg::*;
#(
  parameter int G0   = 2,
  parameter int NGRP = 5,
  localparam int SW  = sec_width(G0, NGRP)
) (
  input  logic [SW-1:0] x,
  input  logic [SW-1:0] y,
  input  logic          ci,
  output logic [SW-1:0] s,
  output logic          co
);
  logic [NGRP:0] gc;
  assign gc[0] = ci;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int GW  = grp_width(G0, g);
    localparam int OFF = grp_offset(G0, g);
    if (g == 0) begin : g_base
      csel_rca #(.W(GW)) u_base (
        .x (x[OFF +: GW]),
        .y (y[OFF +: GW]),
        .ci(gc[g]),
        .s (s[OFF +: GW]),
        .co(gc[g+1])
      );
    end else begin : g_dup
      csel_group #(.W(GW)) u_grp (
        .x  (x[OFF +: GW]),
        .y  (y[OFF +: GW]),
        .sel(gc[g]),
        .s  (s[OFF +: GW]),
        .co (gc[g+1])
      );
    end
  end

  assign co = gc[NGRP];

  // R6: section result matches arithmetic sum of its slice
  always_comb begin
    if (!$isunknown({x, y, ci}))
      p_section_sum_r6: assert ({co, s} == ({1'b0, x} + {1'b0, y} + {{SW{1'b0}}, ci}))
        else $error("section result mismatch");
  end
endmodule

// File: rtl/sqrt_csel_add.sv
module sqrt_csel_add
  import sqrt_csel_pkg::*;
#(
  parameter int WIDTH = 128,
  parameter int G0    = 2,
  parameter int NGRP  = 5
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int SW   = sec_width(G0, NGRP);
  localparam int NSEC = WIDTH / SW;

  logic [NSEC:0] sc;
  assign sc[0] = cin;

  for (genvar k = 0; k < NSEC; k++) begin : g_sec
    csel_section #(.G0(G0), .NGRP(NGRP)) u_sec (
      .x (a[k*SW +: SW]),
      .y (b[k*SW +: SW]),
      .ci(sc[k]),
      .s (sum[k*SW +: SW]),
      .co(sc[k+1])
    );
  end

  assign cout = sc[NSEC];

  // R1: full-width result
  always_comb begin
    if (!$isunknown({a, b, cin}))
      p_total_sum_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
        else $error("adder result mismatch");
  end

  // R2: saturating operands with carry-in roll over to zero
  always_comb begin
    if (!$isunknown({a, b, cin}) && (&a) && (b == '0) && cin)
      p_wrap_zero_r2: assert (cout && (sum == '0))
        else $error("all-ones plus carry did not wrap");
  end
endmodule

// File: tb/sqrt_csel_add_tb.sv
module sqrt_csel_add_tb;
  localparam int W = 128;

  logic         clk = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sqrt_csel_add u_dut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  function automatic logic [W:0] ref_add(logic [W-1:0] x, logic [W-1:0] y, logic c);
    logic [W:0] r;
    r = {1'b0, x} + {1'b0, y};
    r = r + {{W{1'b0}}, c};
    return r;
  endfunction

  function automatic logic [W-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic apply_chk(string req, logic [W-1:0] x, logic [W-1:0] y, logic c);
    logic [W:0] exp_v;
    @(negedge clk);
    a = x; b = y; cin = c;
    #2;
    exp_v = ref_add(x, y, c);
    total++;
    if ({cout, sum} !== exp_v) begin
      bad++;
      $display("FAIL %s: got cout=%0b sum=%h expected cout=%0b sum=%h",
               req, cout, sum, exp_v[W], exp_v[W-1:0]);
    end
  endtask

  initial begin
    int grp_offs[4] = '{2, 4, 7, 11};
    void'($urandom(32'd20240611));
    // R3: zero state and real carry-in into the lowest group
    apply_chk("R1", '0, '0, 1'b0);
    apply_chk("R3", '0, '0, 1'b1);
    // R2: all-ones corners
    apply_chk("R2", '1, '1, 1'b1);
    apply_chk("R2", '1, '0, 1'b1);
    // R7: alternating bits, full propagate
    apply_chk("R7", {32{4'h5}}, {32{4'hA}}, 1'b1);
    apply_chk("R7", {32{4'hA}}, {32{4'h5}}, 1'b0);
    apply_chk("R7", {32{4'h5}}, {32{4'h5}}, 1'b1);
    // R5: every group boundary inside every section
    for (int s = 0; s < W / 16; s++)
      for (int g = 0; g < 4; g++)
        apply_chk("R5", (W'(1) << (s*16 + grp_offs[g])) - W'(1), W'(1), 1'b0);
    // R6: every section boundary, including the 32- and 64-bit joins
    for (int s = 1; s < W / 16; s++) begin
      apply_chk("R6", (W'(1) << (s*16)) - W'(1), W'(1), 1'b0);
      apply_chk("R6", (W'(1) << (s*16)) - W'(1), '0, 1'b1);
    end
    // R4: carry arriving at a group selects the carry-1 candidate only then
    apply_chk("R4", 128'h3, 128'h0, 1'b1);
    apply_chk("R4", 128'h3, 128'h0, 1'b0);
    // R8: inputs changed mid-period show up without an edge
    @(posedge clk);
    #3;
    a = 128'hF; b = 128'h1; cin = 1'b0;
    #2;
    total++;
    if (sum !== 128'h10 || cout !== 1'b0) begin
      bad++;
      $display("FAIL R8: got cout=%0b sum=%h expected cout=0 sum=%h", cout, sum, 128'h10);
    end
    // R1: constrained random
    for (int i = 0; i < 400; i++)
      apply_chk("R1", rnd128(), rnd128(), 1'($urandom));
    // R1: random with long-propagate bias
    for (int i = 0; i < 100; i++) begin
      logic [W-1:0] x = rnd128();
      apply_chk("R1", x, ~x ^ (W'(1) << ($urandom % W)), 1'($urandom));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule